// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block models a small byte-organized serial EEPROM behind an SPI slave port (mode 0: input sampled on the rising edge of the serial clock, output changed on the falling edge). All pins are brought into the system clock domain through a synchroniser, and the serial clock must be slow compared with `clk_i`. The host selects the device, shifts in an instruction byte, and then sends an address, data, or dummy bytes, depending on the instruction. The array sits in internal registers. A down-counter of `WR_CYC` clock cycles stands in for the nonvolatile programming time.

Every change to the array or the status register must pass two gates. The first is the write-enable latch, which only a one-byte enable instruction sets. The second is a protection check: for the array this is the block-protect field, and for the status register it is the lock bit together with the write-protect pin. The status register can be read while the internal write cycle runs. A page buffer collects data bytes, and the buffer is committed at the byte-aligned rising edge of chip select.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x70 and `miso_oe_o` is low while chip select is high. The status layout is: bit0 busy, bit1 write-enable latch, bits3:2 protect field, bits6:4 read as 1, bit7 status lock.
- R2: Opcode 0x06, sent as exactly one byte, sets the write-enable latch. Opcode 0x04, sent the same way, clears it. Either opcode followed by further bytes has no effect.
- R3: An array write or status write issued while the write-enable latch is clear leaves the array and the status unchanged, and it starts no cycle.
- R4: Opcode 0x03 (with address bit 8 carried in opcode bit 3) followed by an address byte returns data MSB first from that address. The address then increments, wrapping from the last byte to 0.
- R5: Opcode 0x02 (with address bit 8 in opcode bit 3), an address byte and N data bytes store the data at consecutive addresses. The address wraps within the aligned 16-byte page.
- R6: An array write needs at least one complete data byte, and chip select must rise on a byte boundary. Otherwise nothing is written and no cycle starts.
- R7: An accepted write sets the busy bit for `WR_CYC` clocks and clears the latch when the cycle ends. While busy, every opcode except 0x05 is ignored: no read data is driven, and 0x06 has no effect.
- R8: Opcode 0x05 returns the live status byte repeatedly for as long as chip select stays low, including during a write cycle.
- R9: Opcode 0x01 with the latch set and one data byte copies data bits 7 and 3:2 into the status register and starts a write cycle.
- R10: The protect field selects what is guarded: 00 protects nothing, 01 the top quarter, 10 the top half, 11 everything. A write to a protected page is dropped without starting a cycle.
- R11: When the lock bit is 1 and `wp_ni` is low, a status write is dropped and the latch is kept. When `wp_ni` is high, the status write proceeds.
- R12: While `hold_ni` is low with chip select low, clock edges are ignored and `miso_oe_o` is low. Shifting resumes when hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data into the device |
| hold_ni | input | 1 | Pause serial transfer, active low |
| wp_ni | input | 1 | Write protect for the status lock, active low |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Output enable for miso_o |

## Verification
The array is first filled through 32 full-page writes, each with an address-dependent pattern, and then read back in one continuous stream of 513 bytes. This shows up any address-bit or carry fault and also checks the wrap at the end of the array. Short writes that start mid-page, incomplete writes, and writes with the latch clear separate page wrap from linear increment, and separate rejection from acceptance. A sweep over all four protect codes against one probe address per quarter tells the protection regions apart. Status transactions issued during a cycle distinguish a live status readout from a snapshot, and distinguish ignored instructions from accepted ones.

// File: rtl/sep_pkg.sv
package sep_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] A8_MASK = 8'hF7; // opcode bit3 carries address bit 8

  typedef enum logic [2:0] {
    P_OP, P_ADDR, P_WDAT, P_SDAT, P_OUT, P_CMD, P_IGN
  } phase_e;

  function automatic logic is_read(input logic [7:0] b);
    return (b & A8_MASK) == OP_READ;
  endfunction

  function automatic logic is_write(input logic [7:0] b);
    return (b & A8_MASK) == OP_WRITE;
  endfunction
endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pipe[0] <= RST_VAL;
    else         pipe[0] <= d_i;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) pipe[s] <= RST_VAL;
      else         pipe[s] <= pipe[s-1];
  end

  assign q_o    = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/sep_wr_timer.sv
module sep_wr_timer #(
  parameter int CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cnt <= '0;
    else if (start_i)   cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;

  assign busy_o = cnt != '0;
  assign done_o = cnt == CW'(1);

  a_r7_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  a_r7_busy_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/sep_protect.sv
module sep_protect #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  logic [1:0] top;
  assign top = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    unique case (bp_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = top == 2'b11;
      2'b10:   prot_o = top[1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W = 9,   // 8 or 9
  parameter int PAGE_W = 4,
  parameter int WR_CYC = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic miso_o,
  output logic miso_oe_o
);
  import sep_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  // pin order: {wp, hold, mosi, sck, cs}
  logic [4:0] pins_raw, pins_s, pins_p;
  assign pins_raw = {wp_ni, hold_ni, mosi_i, sck_i, cs_ni};

  sep_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11001)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_raw), .q_o(pins_s), .prev_o(pins_p)
  );

  logic cs_s, sck_s, mosi_s, hold_s, wp_s;
  assign {wp_s, hold_s, mosi_s, sck_s, cs_s} = pins_s;

  logic act, sck_rise, sck_fall, cs_rise;
  assign act      = !cs_s && hold_s;
  assign sck_rise = act &&  sck_s && !pins_p[1];
  assign sck_fall = act && !sck_s &&  pins_p[1];
  assign cs_rise  = cs_s && !pins_p[0];

  phase_e            phase;
  logic [2:0]        bit_cnt;
  logic [6:0]        rx_sr;
  logic [7:0]        op, tx_sr, sr_new;
  logic [ADDR_W-1:0] addr;
  logic              got, tx_act, miso_q;
  logic              wel, srwd;
  logic [1:0]        bp;
  logic [PAGE-1:0]   mask;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];

  logic busy, done, prot, start_arr, start_sr, wren_go, wrdi_go, aligned;
  logic byte_done, wdat_we;
  logic [7:0] byte_in, status;
  logic [8:0] addr9;
  logic [ADDR_W-1:0] addr_full;

  assign byte_done = sck_rise && bit_cnt == 3'd7;
  assign byte_in   = {rx_sr, mosi_s};
  assign addr9     = {op[3], byte_in};
  assign addr_full = addr9[ADDR_W-1:0];
  assign status    = {srwd, 3'b111, bp, wel, busy};
  assign wdat_we   = byte_done && phase == P_WDAT;
  assign aligned   = bit_cnt == 3'd0;

  assign wren_go   = cs_rise && aligned && phase == P_CMD && op == OP_WREN;
  assign wrdi_go   = cs_rise && aligned && phase == P_CMD && op == OP_WRDI;
  assign start_arr = cs_rise && aligned && phase == P_WDAT && got && wel && !prot;
  assign start_sr  = cs_rise && aligned && phase == P_SDAT && got && wel
                     && !(srwd && !wp_s);

  sep_protect #(.ADDR_W(ADDR_W)) u_prot (.bp_i(bp), .addr_i(addr), .prot_o(prot));

  sep_wr_timer #(.CYC(WR_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(start_arr || start_sr), .busy_o(busy), .done_o(done)
  );

  // serial front end and instruction sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= P_OP;
      bit_cnt <= '0;
      rx_sr   <= '0;
      op      <= '0;
      tx_sr   <= '0;
      sr_new  <= '0;
      addr    <= '0;
      got     <= 1'b0;
      tx_act  <= 1'b0;
      miso_q  <= 1'b0;
      mask    <= '0;
    end else if (cs_s) begin
      phase   <= P_OP;
      bit_cnt <= '0;
      got     <= 1'b0;
      tx_act  <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sr   <= byte_in[6:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (byte_done) begin
        unique case (phase)
          P_OP: begin
            op <= byte_in;
            if (byte_in == OP_RDSR) begin
              tx_sr  <= status;
              tx_act <= 1'b1;
              phase  <= P_OUT;
            end else if (busy)                                phase <= P_IGN;
            else if (is_read(byte_in) || is_write(byte_in))    phase <= P_ADDR;
            else if (byte_in == OP_WRSR)                      phase <= P_SDAT;
            else if (byte_in == OP_WREN || byte_in == OP_WRDI) phase <= P_CMD;
            else                                              phase <= P_IGN;
          end
          P_ADDR: begin
            if (is_read(op)) begin
              tx_sr  <= mem[addr_full];
              tx_act <= 1'b1;
              addr   <= addr_full + 1'b1;
              phase  <= P_OUT;
            end else begin
              addr  <= addr_full;
              mask  <= '0;
              phase <= P_WDAT;
            end
          end
          P_WDAT: begin
            mask[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0]       <= addr[PAGE_W-1:0] + 1'b1; // page wrap
            got                    <= 1'b1;
          end
          P_SDAT: begin
            if (!got) sr_new <= byte_in;
            got <= 1'b1;
          end
          P_OUT: begin
            if (op == OP_RDSR) tx_sr <= status;
            else begin
              tx_sr <= mem[addr];
              addr  <= addr + 1'b1;
            end
          end
          P_CMD:   phase <= P_IGN;
          default: ;
        endcase
      end
      if (sck_fall && tx_act) begin
        miso_q <= tx_sr[7];
        tx_sr  <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  // status register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel  <= 1'b0;
      bp   <= 2'b00;
      srwd <= 1'b0;
    end else begin
      if (done)         wel <= 1'b0;
      else if (wren_go) wel <= 1'b1;
      else if (wrdi_go) wel <= 1'b0;
      if (start_sr) begin
        bp   <= sr_new[3:2];
        srwd <= sr_new[7];
      end
    end
  end

  // page buffer and array
  always_ff @(posedge clk_i) begin
    if (wdat_we) pbuf[addr[PAGE_W-1:0]] <= byte_in;
    for (int i = 0; i < PAGE; i++)
      if (start_arr && mask[i])
        mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = act && tx_act;

  a_r2_wel_set_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(cs_rise));
  a_r7_wel_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !wel);
  a_r10_full_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_arr |-> bp != 2'b11);
  a_r11_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_sr |-> !(srwd && !wp_s));
  a_r12_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s |-> !miso_oe_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !miso_oe_o);
endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int HP = 5;
  localparam int WRC = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic miso, miso_oe;
  int checks = 0, errors = 0;
  logic oe_seen;
  logic [7:0] exp_mem [512];
  logic [7:0] d, s;

  always #5 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(9), .PAGE_W(4), .WR_CYC(WRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_n), .wp_ni(wp_n), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + (a >> 3) + 11);
  endfunction

  task automatic sh(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = miso;
      if (miso_oe) oe_seen = 1'b1;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    sh(tx, 8, rx);
  endtask

  task automatic cs_lo;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_hi;
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo; xb(op, r); cs_hi;
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    cs_lo; xb(8'h05, r); xb(8'h00, st); cs_hi;
  endtask

  task automatic wait_idle(output logic [7:0] st);
    for (int k = 0; k < 100; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  function automatic logic [7:0] opa(input logic [7:0] op, input int a);
    return op | (a >= 256 ? 8'h08 : 8'h00);
  endfunction

  task automatic wr1(input int a, input logic [7:0] v);
    logic [7:0] r;
    cs_lo; xb(opa(8'h02, a), r); xb(8'(a), r); xb(v, r); cs_hi;
  endtask

  task automatic rd1(input int a, output logic [7:0] v);
    logic [7:0] r;
    cs_lo; xb(opa(8'h03, a), r); xb(8'(a), r); xb(8'h00, v); cs_hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe idle", int'(miso_oe), 0);
    rdsr(s); check("R1 status", s, 8'h70);

    // R2 latch set/clear, extra byte voids command
    cmd1(8'h06); rdsr(s); check("R2 wren", s, 8'h72);
    cmd1(8'h04); rdsr(s); check("R2 wrdi", s, 8'h70);
    cs_lo; xb(8'h06, r); xb(8'h00, r); cs_hi;
    rdsr(s); check("R2 wren long", s, 8'h70);

    // R5/R7 fill every page
    for (int p = 0; p < 32; p++) begin
      cmd1(8'h06);
      cs_lo; xb(opa(8'h02, p * 16), r); xb(8'(p * 16), r);
      for (int i = 0; i < 16; i++) begin
        xb(pat(p * 16 + i), r);
        exp_mem[p * 16 + i] = pat(p * 16 + i);
      end
      cs_hi;
      if (p == 0) begin rdsr(s); check("R7 busy status", s, 8'h73); end
      wait_idle(s); check("R7 wel auto clear", s, 8'h70);
    end

    // R4 stream read across A8 and array end
    cs_lo; xb(8'h03, r); xb(8'h00, r);
    for (int a = 0; a <= 512; a++) begin
      xb(8'h00, d); check("R4 stream", d, exp_mem[a % 512]);
    end
    cs_hi;
    cs_lo; xb(8'h0B, r); xb(8'hFE, r);
    for (int a = 510; a < 513; a++) begin
      xb(8'h00, d); check("R4 a8 opcode wrap", d, exp_mem[a % 512]);
    end
    cs_hi;

    // R5 page wrap from mid page
    cmd1(8'h06);
    cs_lo; xb(8'h02, r); xb(8'h1E, r);
    for (int i = 0; i < 4; i++) begin
      xb(8'hA1 + 8'(i), r);
      exp_mem[16 + ((14 + i) % 16)] = 8'hA1 + 8'(i);
    end
    cs_hi; wait_idle(s);
    cs_lo; xb(8'h03, r); xb(8'h10, r);
    for (int a = 16; a < 32; a++) begin
      xb(8'h00, d); check("R5 page wrap", d, exp_mem[a]);
    end
    cs_hi;

    // R3 write with latch clear
    wr1(5, ~exp_mem[5]); rdsr(s); check("R3 no cycle", s, 8'h70);
    rd1(5, d); check("R3 array kept", d, exp_mem[5]);
    cs_lo; xb(8'h01, r); xb(8'h0C, r); cs_hi;
    rdsr(s); check("R3 status kept", s, 8'h70);

    // R6 incomplete writes
    cmd1(8'h06);
    cs_lo; xb(8'h02, r); xb(8'h06, r); sh(8'hFF, 4, r); cs_hi;
    rdsr(s); check("R6 partial byte", s, 8'h72);
    cs_lo; xb(8'h02, r); xb(8'h07, r); cs_hi;
    rdsr(s); check("R6 no data", s, 8'h72);
    rd1(6, d); check("R6 addr6 kept", d, exp_mem[6]);
    rd1(7, d); check("R6 addr7 kept", d, exp_mem[7]);
    cmd1(8'h04); rdsr(s); check("R2 wrdi after", s, 8'h70);

    // R8 live status within one transaction
    cmd1(8'h06); wr1(8'h40, 8'h5A); exp_mem[8'h40] = 8'h5A;
    cs_lo; xb(8'h05, r); xb(8'h00, d); check("R8 first busy", d, 8'h73);
    for (int k = 0; k < 60; k++) begin
      xb(8'h00, d);
      if (!d[0]) break;
    end
    check("R8 live end", d, 8'h70);
    cs_hi;

    // R7 instructions ignored while busy
    cmd1(8'h06); wr1(8'h41, 8'hC3); exp_mem[8'h41] = 8'hC3;
    cmd1(8'h06);
    oe_seen = 1'b0;
    cs_lo; xb(8'h03, r); xb(8'h41, r); xb(8'h00, r); cs_hi;
    check("R7 read ignored", int'(oe_seen), 0);
    wait_idle(s); check("R7 wren ignored", s, 8'h70);
    rd1(8'h41, d); check("R7 data written", d, 8'hC3);

    // R9/R10 protect sweep
    for (int bpv = 0; bpv < 4; bpv++) begin
      cmd1(8'h06);
      cs_lo; xb(8'h01, r); xb(8'(bpv << 2), r); cs_hi;
      wait_idle(s); check("R9 status write", s, 8'h70 | 8'(bpv << 2));
      for (int q = 0; q < 4; q++) begin
        int a;
        bit pr;
        logic [7:0] v;
        a = q * 128 + 32 + bpv;
        pr = (bpv == 1 && q == 3) || (bpv == 2 && q >= 2) || bpv == 3;
        v = ~exp_mem[a];
        cmd1(8'h06); wr1(a, v);
        if (pr) begin
          rdsr(s); check("R10 protected no cycle", s, 8'h72 | 8'(bpv << 2));
          cmd1(8'h04);
        end else begin
          wait_idle(s); exp_mem[a] = v;
        end
        rd1(a, d); check("R10 region", d, exp_mem[a]);
      end
    end
    cmd1(8'h06); cs_lo; xb(8'h01, r); xb(8'h00, r); cs_hi;
    wait_idle(s); check("R9 clear bp", s, 8'h70);

    // R11 status lock with pin
    cmd1(8'h06); cs_lo; xb(8'h01, r); xb(8'h80, r); cs_hi;
    wait_idle(s); check("R11 lock set", s, 8'hF0);
    wp_n = 1'b0;
    cmd1(8'h06); cs_lo; xb(8'h01, r); xb(8'h0C, r); cs_hi;
    rdsr(s); check("R11 locked", s, 8'hF2);
    wp_n = 1'b1;
    cs_lo; xb(8'h01, r); xb(8'h00, r); cs_hi;
    wait_idle(s); check("R11 pin high", s, 8'h70);

    // R12 hold
    cs_lo; sh(8'h05, 4, r);
    hold_n = 1'b0; repeat (HP) @(negedge clk);
    mosi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; repeat (HP) @(negedge clk);
      sck = 1'b0; repeat (HP) @(negedge clk);
    end
    hold_n = 1'b1; repeat (HP) @(negedge clk);
    sh(8'h50, 4, r);
    xb(8'h00, d); check("R12 edges ignored", d, 8'h70);
    hold_n = 1'b0; repeat (HP) @(negedge clk);
    check("R12 oe low", int'(miso_oe), 0);
    hold_n = 1'b1; repeat (HP) @(negedge clk);
    check("R12 oe back", int'(miso_oe), 1);
    cs_hi;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule